// File: doc/BRIEF.md
# Cascadable Binary Up/Down Counter

This block is a chain of 4-bit binary counter stages that all share one clock. On each rising edge an enabled chain counts up or down, as one direction input selects. Each stage passes an active-low carry enable to the next stage, so the whole chain acts as a single counter that is `NSTAGE*STAGE_W` bits wide. The carry-out of a stage follows its carry-in through gates only, with no register on that path. This lets stages that are clocked in parallel ripple their enables within one cycle, with no added gating.

Two controls act without waiting for the clock. A high reset clears the count. A high load enable forces the count to the parallel load value and holds it there. Reset wins when both are high. The load value is taken into the state register when load enable rises and again on every clock edge while load enable stays high. While load enable is high, the outputs follow the load inputs directly. When load enable drops, the count keeps the last value captured.

Top module: `updn_chain`

## Requirements
- R1: While `rst` is high, `count` is zero at once, with no clock edge needed, and it stays zero through clock edges.
- R2: When `rst`, `load_en` and `cin_n` are low and `dir_up` is 1, each rising clock edge adds one to the full-width `count`.
- R3: When `rst`, `load_en` and `cin_n` are low and `dir_up` is 0, each rising clock edge subtracts one from the full-width `count`.
- R4: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R5: While `cin_n` is 1, clock edges leave `count` unchanged.
- R6: While `load_en` is high and `rst` is low, `count` equals `load_val` with no clock edge needed, and it follows changes of `load_val`. After `load_en` falls, `count` keeps the last loaded value.
- R7: When `rst` and `load_en` are both high, `count` is zero.
- R8: `cout_n` is 0 exactly when `cin_n` is 0 and `count` is at its terminal value: all ones when `dir_up`=1, zero when `dir_up`=0. `cout_n` responds to `cin_n` and `dir_up` without a clock edge.
- R9: A higher stage advances only on an edge at which every lower stage is at its terminal value. Carries and borrows therefore propagate across stage boundaries, for example 0x0F+1 gives 0x10 and 0x10-1 gives 0x0F.
- R10: A clock edge at which `rst` or `load_en` is high causes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high |
| load_en | input | 1 | Asynchronous parallel load enable, active high |
| load_val | input | NSTAGE*STAGE_W | Parallel load value |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cin_n | input | 1 | Chain carry enable, active low |
| count | output | NSTAGE*STAGE_W | Counter value |
| cout_n | output | 1 | Chain carry-out, active low |

## Verification
If the state of a stage is wrong, `count` shows it at the next sampling point, and the error stays until a load or reset clears it. A wrong carry between stages shows up later. It appears only at the first edge where a lower stage sits at its terminal value, so the tests walk the count across the 0x0F/0x10 boundary in both directions. An error in the carry-out terms shows on `cout_n` within the same cycle, because that path has no register. The tests therefore toggle `cin_n` and `dir_up` between clock edges and check `cout_n` right after each change.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Direction encoding as seen on the dir_up pin
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    function automatic dir_e to_dir(input logic up_bit);
        return up_bit ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/updn_step.sv
// Next-count arithmetic for one stage: +1, -1 or hold.
module updn_step #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         en_i,
    output logic [W-1:0] nxt_o
);
    import updn_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
            unique case (to_dir(up_i))
                DIR_UP:   nxt_o = cur_i + ONE;
                DIR_DOWN: nxt_o = cur_i - ONE;
                default:  nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/updn_term.sv
// Terminal-value detection and active-low carry generation for one stage.
module updn_term #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic         up_i,
    input  logic         cin_n_i,
    output logic         at_term_o,
    output logic         cout_n_o
);
    import updn_pkg::*;

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] BOT_VAL = '0;

    always_comb begin
        unique case (to_dir(up_i))
            DIR_UP:   at_term_o = (cnt_i == TOP_VAL);
            DIR_DOWN: at_term_o = (cnt_i == BOT_VAL);
            default:  at_term_o = 1'b0;
        endcase
        cout_n_o = ~(~cin_n_i & at_term_o);
    end

endmodule

// File: rtl/updn_stage.sv
// One counter stage: registered count with asynchronous clear and load.
module updn_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dir_up,
    input  logic         cin_n,
    output logic [W-1:0] cnt_o,
    output logic         cout_n
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t          st_d;
    st_t          st_q;
    logic [W-1:0] step_nxt;
    logic         at_term;

    updn_step #(.W(W)) u_step (
        .cur_i (st_q.cnt),
        .up_i  (dir_up),
        .en_i  (~cin_n),
        .nxt_o (step_nxt)
    );

    // Visible count: clear wins, then transparent load, then stored state
    always_comb begin
        if (rst)          cnt_o = '0;
        else if (load_en) cnt_o = load_val;
        else              cnt_o = st_q.cnt;
    end

    updn_term #(.W(W)) u_term (
        .cnt_i     (cnt_o),
        .up_i      (dir_up),
        .cin_n_i   (cin_n),
        .at_term_o (at_term),
        .cout_n_o  (cout_n)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = step_nxt;
    end

    always_ff @(posedge clk or posedge rst or posedge load_en) begin
        if (rst)          st_q <= '0;
        else if (load_en) st_q <= '{cnt: load_val};
        else              st_q <= st_d;
    end

endmodule

// File: rtl/updn_chain.sv
// Stages sharing one clock, carry of each feeding the carry-in of the next.
module updn_chain #(
    parameter int unsigned NSTAGE  = 2,
    parameter int unsigned STAGE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_en,
    input  logic [NSTAGE*STAGE_W-1:0]   load_val,
    input  logic                        dir_up,
    input  logic                        cin_n,
    output logic [NSTAGE*STAGE_W-1:0]   count,
    output logic                        cout_n
);

    localparam int unsigned TOT_W = NSTAGE * STAGE_W;

    logic [NSTAGE:0] link_n;

    assign link_n[0] = cin_n;
    assign cout_n    = link_n[NSTAGE];

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .load_en  (load_en),
            .load_val (load_val[s*STAGE_W +: STAGE_W]),
            .dir_up   (dir_up),
            .cin_n    (link_n[s]),
            .cnt_o    (count[s*STAGE_W +: STAGE_W]),
            .cout_n   (link_n[s+1])
        );
    end

endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int unsigned NSTAGE  = 2,
    parameter int unsigned STAGE_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      load_en,
    input logic [NSTAGE*STAGE_W-1:0] load_val,
    input logic                      dir_up,
    input logic                      cin_n,
    input logic [NSTAGE*STAGE_W-1:0] count,
    input logic                      cout_n
);
    localparam int unsigned TW = NSTAGE * STAGE_W;
    localparam logic [TW-1:0] ONE = TW'(1);

    // R1 R7
    always @(posedge clk) begin
        if (rst) begin
            clear_zero_chk: assert (count == '0);
        end
    end

    // R2 R4 R9
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !load_en && !cin_n && dir_up) && !load_en)
        |-> (count == $past(count) + ONE));

    // R3 R4 R9
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !load_en && !cin_n && !dir_up) && !load_en)
        |-> (count == $past(count) - ONE));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !load_en && cin_n) && !load_en)
        |-> $stable(count));

    // R6
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (count == load_val));

    // R8
    carry_out_chk: assert property (@(posedge clk) disable iff (rst)
        cout_n == !(!cin_n && (dir_up ? (&count) : (count == '0))));

endmodule

bind updn_chain updn_chain_chk #(.NSTAGE(NSTAGE), .STAGE_W(STAGE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .dir_up   (dir_up),
    .cin_n    (cin_n),
    .count    (count),
    .cout_n   (cout_n)
);

// File: tb/sim_updn_chain.sv
module sim_updn_chain;

    localparam int unsigned NS = 2;
    localparam int unsigned SW = 4;
    localparam int unsigned TW = NS * SW;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_en;
    logic [TW-1:0] load_val;
    logic          dir_up;
    logic          cin_n;
    logic [TW-1:0] count;
    logic          cout_n;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    updn_chain #(.NSTAGE(NS), .STAGE_W(SW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .dir_up   (dir_up),
        .cin_n    (cin_n),
        .count    (count),
        .cout_n   (cout_n)
    );

    typedef struct packed {
        logic       ld;
        logic [7:0] val;
        logic       up;
        logic       cn;
        logic [7:0] exp_q;
        logic       exp_co;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h0E, 1'b1, 1'b0, 8'h0E, 1'b1}, // R6 load
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h0F, 1'b1}, // R2
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h10, 1'b1}, // R9 carry
        '{1'b0, 8'h00, 1'b1, 1'b1, 8'h10, 1'b1}, // R5 hold
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h0F, 1'b1}, // R3 R9 borrow
        '{1'b1, 8'hFE, 1'b1, 1'b0, 8'hFE, 1'b1}, // R6
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b0}, // R8 up terminal
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1}, // R4 up wrap
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1}, // R5 R8 hold at terminal
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1}, // R4 down wrap
        '{1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b1}, // R6
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0}  // R8 down terminal
    };

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_val = '0; dir_up = 1'b1; cin_n = 1'b0;
        tick();
        chk("R1 reset count", count, 8'h00);
        chk("R8 reset carry", TW'(cout_n), TW'(1'b1));
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            load_en  = VEC[i].ld;
            load_val = VEC[i].val;
            dir_up   = VEC[i].up;
            cin_n    = VEC[i].cn;
            tick();
            chk($sformatf("vec%0d count", i), count, VEC[i].exp_q);
            chk($sformatf("vec%0d R8 carry", i), TW'(cout_n), TW'(VEC[i].exp_co));
        end
        load_en = 1'b0;

        // R6: asynchronous, transparent load
        load_en = 1'b1; load_val = 8'h5A; #1;
        chk("R6 async load", count, 8'h5A);
        load_val = 8'h33; #1;
        chk("R6 follow", count, 8'h33);
        tick();
        load_en = 1'b0; dir_up = 1'b1; cin_n = 1'b0; #1;
        chk("R6 R10 held after load", count, 8'h33);
        tick();
        chk("R2 count after load", count, 8'h34);

        // R1 R7 R10: asynchronous clear with priority
        rst = 1'b1; #1;
        chk("R1 async clear", count, 8'h00);
        load_en = 1'b1; load_val = 8'h77; #1;
        chk("R7 clear over load", count, 8'h00);
        tick();
        chk("R1 R10 clear held", count, 8'h00);
        load_en = 1'b0; #1;
        rst = 1'b0; #1;
        chk("R10 no count under clear", count, 8'h00);
        tick();
        chk("R2 resume", count, 8'h01);

        // R8: carry path without clock
        load_en = 1'b1; load_val = 8'hFF;
        tick();
        load_en = 1'b0; dir_up = 1'b1; cin_n = 1'b1; #1;
        chk("R8 carry gated by cin", TW'(cout_n), TW'(1'b1));
        cin_n = 1'b0; #1;
        chk("R8 carry from cin", TW'(cout_n), TW'(1'b0));
        dir_up = 1'b0; #1;
        chk("R8 carry follows dir", TW'(cout_n), TW'(1'b1));
        tick();
        chk("R3 down step", count, 8'hFE);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule